// File: doc/BRIEF.md
# Three-wire serial EEPROM master

This block lets a host-side controller talk to a small serial EEPROM over four wires: a select line, a clock line, a data line out to the device and a data line back from it. The host presents one operation at a time: read a 16-bit word, write a 16-bit word, enable erase/write, or disable erase/write. Read and write carry a 6-bit word address. The block then produces the whole pin sequence. This covers a start bit and one clock pulse, an 8-bit command shifted out most significant bit first, and 16 data bits shifted in or out. For writes it also polls the device until the device signals that programming is finished.

Every pin level is held for one half-bit period. That period is a parameterised count of system clocks, chosen so that about 30 µs is reached at the system clock rate. The host sees `req_ready` while the block is idle and `busy` during an operation. It also sees a one-cycle `done` pulse, which comes with the returned read word and a flag telling whether the completion poll ran out.

Top module: `serprom_master`

## Requirements
- R1: After reset, `ee_cs`, `ee_sk` and `ee_do` are low, `busy` and `done` are low and `req_ready` is high; whenever `busy` is low the three device pins are low.
- R2: Each pin state lasts exactly HALF_CYCLES clocks, starting in the cycle after acceptance. Every operation opens with a phase of select high, data-out high and clock low (the start bit), followed by a phase with the clock high and data-out still high.
- R3: The 8-bit command is sent MSB first as a low-clock phase carrying the bit, followed by a high-clock phase with the same bit, and then one phase of select high with clock and data-out low. `req_op` codes are 0 read, 1 write, 2 enable, 3 disable, and the command bytes are 0x80|addr, 0x40|addr, 0x30 and 0x00.
- R4: A read then gives 16 pairs of phases, clock high and then clock low, with data-out low. `ee_di` is sampled at the end of each low phase, MSB first, and the assembled word is on `rd_data` in the `done` cycle.
- R5: A write sends 16 data bits MSB first with the same low/high phase pairs as the command. It then gives one phase of select high with clock low, and one phase with select low.
- R6: After the write data, select is raised for one phase with the clock low. Clock-high/clock-low phase pairs follow, with `ee_di` sampled at the end of each low phase, and polling stops after the first sample that reads 1.
- R7: If POLL_LIMIT samples in a row read 0, polling stops and `poll_timeout` is 1 in the `done` cycle; otherwise it is 0. It is cleared when the next request is accepted.
- R8: Every operation ends with one phase of select low. `done` then pulses for exactly one cycle, in which `busy` is already low.
- R9: A request is accepted only in a cycle where `req_ready` is high; `req_valid` while busy has no effect on the pins or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request |
| req_op | input | 2 | 0 read, 1 write, 2 enable, 3 disable |
| req_addr | input | ADDR_W | Word address for read/write |
| req_wdata | input | DATA_W | Word to write |
| req_ready | output | 1 | Block idle, request will be taken |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Read word, valid with done |
| poll_timeout | output | 1 | Write completion poll expired, valid with done |
| ee_cs | output | 1 | Device select |
| ee_sk | output | 1 | Device clock |
| ee_do | output | 1 | Serial data to device |
| ee_di | input | 1 | Serial data from device |

## Verification
Every operation code is run, and each pin is compared cycle by cycle with a phase list built from the requirements, so a wrong command byte, bit order or phase length shows at once. Reads use the words 0xA5C3, 0xFFFF and 0x0001 on the top and bottom addresses. These separate MSB-first from LSB-first assembly and catch a lost first or last bit. Writes are run with the device ready on the first poll, after a few polls and never. These show where polling stops, whether the watchdog fires, and that its flag clears on the next request. A request raised in the middle of a read must leave the waveform untouched.

// File: rtl/serprom_pkg.sv
package serprom_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_WREN  = 2'd2,
    OP_WRDIS = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START_LO,
    ST_START_HI,
    ST_CMD_LO,
    ST_CMD_HI,
    ST_CMD_END,
    ST_RD_HI,
    ST_RD_LO,
    ST_DAT_LO,
    ST_DAT_HI,
    ST_WR_END,
    ST_CS_GAP,
    ST_POLL_CS,
    ST_POLL_HI,
    ST_POLL_LO,
    ST_FINISH
  } state_e;

  typedef struct packed {
    logic cs;
    logic sk;
    logic dout;
  } pins_t;

  // Pin levels for each phase; cmd_bit/dat_bit are the current shifter MSBs.
  function automatic pins_t pins_for(state_e st, logic cmd_bit, logic dat_bit);
    pins_t p;
    p = '{cs: 1'b1, sk: 1'b0, dout: 1'b0};
    case (st)
      ST_IDLE, ST_CS_GAP, ST_FINISH: p.cs = 1'b0;
      ST_START_LO: p.dout = 1'b1;
      ST_START_HI: begin p.sk = 1'b1; p.dout = 1'b1; end
      ST_CMD_LO:   p.dout = cmd_bit;
      ST_CMD_HI:   begin p.sk = 1'b1; p.dout = cmd_bit; end
      ST_DAT_LO:   p.dout = dat_bit;
      ST_DAT_HI:   begin p.sk = 1'b1; p.dout = dat_bit; end
      ST_RD_HI, ST_POLL_HI: p.sk = 1'b1;
      default: ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/serprom_halfbit_timer.sv
module serprom_halfbit_timer #(
  parameter int unsigned HALF_CYCLES = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CNT_W = $clog2(HALF_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/serprom_shreg.sv
module serprom_shreg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (load)   q <= load_val;
    else if (shift)  q <= {q[W-2:0], sin};
  end
endmodule

// File: rtl/serprom_sequencer.sv
module serprom_sequencer
  import serprom_pkg::*;
#(
  parameter int unsigned CMD_W      = 8,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned POLL_LIMIT = 4096
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  op_e    start_op,
  input  logic   tick,
  input  logic   di,
  output state_e st,
  output logic   cmd_shift,
  output logic   dat_shift,
  output logic   dat_sin,
  output logic   done,
  output logic   timeout
);
  localparam int unsigned MAXB   = (DATA_W > CMD_W) ? DATA_W : CMD_W;
  localparam int unsigned BIT_W  = $clog2(MAXB);
  localparam int unsigned POLL_W = $clog2(POLL_LIMIT + 1);

  op_e               op_q;
  logic [BIT_W-1:0]  bit_cnt;
  logic [POLL_W-1:0] poll_cnt;
  logic              err_q;

  logic last_cmd_bit, last_dat_bit, poll_expired;
  assign last_cmd_bit = (bit_cnt == BIT_W'(CMD_W - 1));
  assign last_dat_bit = (bit_cnt == BIT_W'(DATA_W - 1));
  assign poll_expired = (poll_cnt == POLL_W'(POLL_LIMIT - 1));

  assign cmd_shift = tick && (st == ST_CMD_HI);
  assign dat_shift = tick && ((st == ST_DAT_HI) || (st == ST_RD_LO));
  assign dat_sin   = (st == ST_RD_LO) ? di : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      op_q     <= OP_READ;
      bit_cnt  <= '0;
      poll_cnt <= '0;
      err_q    <= 1'b0;
      done     <= 1'b0;
      timeout  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        st       <= ST_START_LO;
        op_q     <= start_op;
        bit_cnt  <= '0;
        poll_cnt <= '0;
        err_q    <= 1'b0;
        timeout  <= 1'b0;
      end else if (tick) begin
        case (st)
          ST_START_LO: st <= ST_START_HI;
          ST_START_HI: begin st <= ST_CMD_LO; bit_cnt <= '0; end
          ST_CMD_LO:   st <= ST_CMD_HI;
          ST_CMD_HI: begin
            if (last_cmd_bit) st <= ST_CMD_END;
            else begin st <= ST_CMD_LO; bit_cnt <= bit_cnt + 1'b1; end
          end
          ST_CMD_END: begin
            bit_cnt <= '0;
            case (op_q)
              OP_READ:  st <= ST_RD_HI;
              OP_WRITE: st <= ST_DAT_LO;
              default:  st <= ST_FINISH;
            endcase
          end
          ST_RD_HI: st <= ST_RD_LO;
          ST_RD_LO: begin
            if (last_dat_bit) st <= ST_FINISH;
            else begin st <= ST_RD_HI; bit_cnt <= bit_cnt + 1'b1; end
          end
          ST_DAT_LO: st <= ST_DAT_HI;
          ST_DAT_HI: begin
            if (last_dat_bit) st <= ST_WR_END;
            else begin st <= ST_DAT_LO; bit_cnt <= bit_cnt + 1'b1; end
          end
          ST_WR_END:  st <= ST_CS_GAP;
          ST_CS_GAP:  st <= ST_POLL_CS;
          ST_POLL_CS: begin st <= ST_POLL_HI; poll_cnt <= '0; end
          ST_POLL_HI: st <= ST_POLL_LO;
          ST_POLL_LO: begin
            if (di) st <= ST_FINISH;
            else if (poll_expired) begin st <= ST_FINISH; err_q <= 1'b1; end
            else begin st <= ST_POLL_HI; poll_cnt <= poll_cnt + 1'b1; end
          end
          ST_FINISH: begin
            st      <= ST_IDLE;
            done    <= 1'b1;
            timeout <= err_q;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serprom_master.sv
module serprom_master
  import serprom_pkg::*;
#(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned HALF_CYCLES = 1500,
  parameter int unsigned POLL_LIMIT  = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              poll_timeout,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_do,
  input  logic              ee_di
);
  localparam int unsigned CMD_W = ADDR_W + 2;

  // Command byte: two opcode bits above the address; enable uses 11 at the top of the address field.
  function automatic logic [CMD_W-1:0] make_cmd(op_e op, logic [ADDR_W-1:0] addr);
    case (op)
      OP_READ:  return {2'b10, addr};
      OP_WRITE: return {2'b01, addr};
      OP_WREN:  return {2'b00, 2'b11, {(ADDR_W-2){1'b0}}};
      default:  return '0;
    endcase
  endfunction

  state_e           st;
  logic             phase_tick;
  logic             accept;
  logic             cmd_shift, dat_shift, dat_sin;
  logic [CMD_W-1:0] cmd_q;
  logic [DATA_W-1:0] dat_q;
  pins_t            pins;

  assign busy      = (st != ST_IDLE);
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  serprom_halfbit_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(phase_tick)
  );

  serprom_shreg #(.W(CMD_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .load_val(make_cmd(op_e'(req_op), req_addr)),
    .shift(cmd_shift), .sin(1'b0), .q(cmd_q)
  );

  serprom_shreg #(.W(DATA_W)) u_dat (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(req_wdata),
    .shift(dat_shift), .sin(dat_sin), .q(dat_q)
  );

  serprom_sequencer #(
    .CMD_W(CMD_W), .DATA_W(DATA_W), .POLL_LIMIT(POLL_LIMIT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .start_op(op_e'(req_op)),
    .tick(phase_tick), .di(ee_di), .st(st),
    .cmd_shift(cmd_shift), .dat_shift(dat_shift), .dat_sin(dat_sin),
    .done(done), .timeout(poll_timeout)
  );

  assign pins    = pins_for(st, cmd_q[CMD_W-1], dat_q[DATA_W-1]);
  assign ee_cs   = pins.cs;
  assign ee_sk   = pins.sk;
  assign ee_do   = pins.dout;
  assign rd_data = dat_q;
endmodule

// File: rtl/serprom_checker.sv
module serprom_checker (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic req_valid,
  input logic req_ready,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_do,
  input logic poll_timeout,
  input logic phase_tick
);
  AST_IDLE_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ee_cs && !ee_sk && !ee_do)); // R1

  AST_CLOCK_UNDER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs); // R2

  AST_PINS_HELD_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !phase_tick) |=> $stable({ee_cs, ee_sk, ee_do})); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8

  AST_TIMEOUT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(poll_timeout) |-> done); // R7

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy); // R9
endmodule

bind serprom_master serprom_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .req_valid(req_valid), .req_ready(req_ready),
  .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_do(ee_do),
  .poll_timeout(poll_timeout), .phase_tick(phase_tick)
);

// File: tb/test_serprom_master.sv
module test_serprom_master;
  localparam int CLK_PERIOD = 10;
  localparam int HALF  = 3;
  localparam int LIMIT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [5:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, busy, done, poll_timeout, ee_cs, ee_sk, ee_do;
  logic [15:0] rd_data;
  logic ee_di = 1'b0;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit    cs;
    bit    sk;
    bit    dout;
    bit    di;
    string req;
  } cyc_t;
  cyc_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  serprom_master #(.ADDR_W(6), .DATA_W(16), .HALF_CYCLES(HALF), .POLL_LIMIT(LIMIT)) i_serprom_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .busy(busy), .done(done), .rd_data(rd_data), .poll_timeout(poll_timeout),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_do(ee_do), .ee_di(ee_di)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic push_phase(input bit cs, input bit sk, input bit d, input bit di, input string req);
    for (int i = 0; i < HALF; i++) exp_q.push_back('{cs, sk, d, di, req});
  endtask

  // Builds the expected pin timeline from the requirement text.
  task automatic build(input int op, input logic [5:0] addr, input logic [15:0] wdata,
                       input logic [15:0] rword, input int k);
    logic [7:0] cmd;
    int n;
    exp_q.delete();
    case (op)
      0: cmd = 8'h80 | {2'b00, addr};
      1: cmd = 8'h40 | {2'b00, addr};
      2: cmd = 8'h30;
      default: cmd = 8'h00;
    endcase
    push_phase(1, 0, 1, 0, "R2");
    push_phase(1, 1, 1, 0, "R2");
    for (int b = 7; b >= 0; b--) begin
      push_phase(1, 0, cmd[b], 0, "R3");
      push_phase(1, 1, cmd[b], 0, "R3");
    end
    push_phase(1, 0, 0, 0, "R3");
    if (op == 0) begin
      for (int b = 15; b >= 0; b--) begin
        push_phase(1, 1, 0, rword[b], "R4");
        push_phase(1, 0, 0, rword[b], "R4");
      end
    end else if (op == 1) begin
      for (int b = 15; b >= 0; b--) begin
        push_phase(1, 0, wdata[b], 0, "R5");
        push_phase(1, 1, wdata[b], 0, "R5");
      end
      push_phase(1, 0, 0, 0, "R5");
      push_phase(0, 0, 0, 0, "R5");
      push_phase(1, 0, 0, 0, "R6");
      n = (k < LIMIT) ? k + 1 : LIMIT;
      for (int p = 0; p < n; p++) begin
        push_phase(1, 1, 0, (p >= k), "R6");
        push_phase(1, 0, 0, (p >= k), "R6");
      end
    end
    push_phase(0, 0, 0, 0, "R8");
  endtask

  task automatic run_op(input int op, input logic [5:0] addr, input logic [15:0] wdata,
                        input logic [15:0] rword, input int k, input bit poke);
    bit exp_to;
    int idx;
    build(op, addr, wdata, rword, k);
    exp_to = (op == 1) && (k >= LIMIT);
    @(negedge clk);
    chk(req_ready === 1'b1, "R9", "ready before request", req_ready, 1);
    req_valid = 1'b1; req_op = op[1:0]; req_addr = addr; req_wdata = wdata;
    @(negedge clk);
    req_valid = 1'b0; req_op = 2'd3; req_addr = '0; req_wdata = 16'hFFFF;
    idx = 0;
    foreach (exp_q[i]) begin
      chk(ee_cs === exp_q[i].cs, exp_q[i].req, "ee_cs", ee_cs, exp_q[i].cs);
      chk(ee_sk === exp_q[i].sk, exp_q[i].req, "ee_sk", ee_sk, exp_q[i].sk);
      chk(ee_do === exp_q[i].dout, exp_q[i].req, "ee_do", ee_do, exp_q[i].dout);
      chk(busy === 1'b1 && req_ready === 1'b0 && done === 1'b0, "R9",
          "busy/ready/done during operation", {busy, req_ready, done}, 3'b100);
      ee_di = exp_q[i].di;
      if (poke) begin
        // R9: a request while busy must leave the waveform unchanged
        if (idx == 5) begin req_valid = 1'b1; req_op = 2'd1; req_addr = 6'h3F; end
        else req_valid = 1'b0;
      end
      idx++;
      @(negedge clk);
    end
    ee_di = 1'b0;
    chk(done === 1'b1, "R8", "done pulse", done, 1);
    chk(busy === 1'b0 && req_ready === 1'b1, "R8", "idle in done cycle", {busy, req_ready}, 2'b01);
    chk(poll_timeout === exp_to, "R7", "poll_timeout", poll_timeout, exp_to);
    if (op == 0) chk(rd_data === rword, "R4", "rd_data", rd_data, rword);
    @(negedge clk);
    chk(done === 1'b0, "R8", "done one cycle only", done, 0);
    chk(!ee_cs && !ee_sk && !ee_do, "R1", "pins low when idle", {ee_cs, ee_sk, ee_do}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!ee_cs && !ee_sk && !ee_do, "R1", "pins in reset", {ee_cs, ee_sk, ee_do}, 0);
    chk(!busy && !done && req_ready, "R1", "status in reset", {busy, done, req_ready}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && req_ready, "R1", "idle after reset", {busy, req_ready}, 2'b01);

    run_op(2, 6'h00, 16'h0000, 16'h0000, 0, 0);     // R3 enable
    run_op(0, 6'h15, 16'h0000, 16'hA5C3, 0, 0);     // R4 read
    run_op(0, 6'h3F, 16'h0000, 16'hFFFF, 0, 0);     // R4 top address
    run_op(0, 6'h00, 16'h0000, 16'h0001, 0, 1);     // R4, R9 poke while busy
    run_op(1, 6'h2A, 16'h1234, 16'h0000, 2, 0);     // R5, R6 ready after polls
    run_op(1, 6'h01, 16'h8001, 16'h0000, 0, 0);     // R6 ready on first sample
    run_op(1, 6'h3F, 16'hBEEF, 16'h0000, 10, 0);    // R7 never ready
    run_op(1, 6'h10, 16'h0F0F, 16'h0000, 1, 0);     // R7 flag cleared
    run_op(3, 6'h00, 16'h0000, 16'h0000, 0, 0);     // R3 disable

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule